// File: doc/BRIEF.md
# Dual-Clock True Dual-Port RAM with Per-Port Read Latency

This block is a synchronous memory with two fully independent ports, A and B, each with its own clock and reset. Either port can read or write any word, and both can target the same word on the same edge. Each port samples its address, write data, read/write control and a pair of select inputs on the rising edge of its own clock. A port is selected when its active-low select is low and its active-high select is high. The two selects make depth expansion across several instances possible without glue logic.

Each port has a static latency input. In flow-through mode, read data shows up in the cycle right after the address edge. In pipelined mode it shows up one cycle later. After a deselect, a pipelined port needs two selected edges in a row before it drives data again. An active-low output enable blanks the read output at once, without a clock edge. A valid flag stands in for a tri-state bus: when it is low, the data output is zero.

The default geometry in the code base is 2^10 words of 8 bits. A 64K-word instance sets `ADDR_W` to 16. The address counter that feeds each port sits outside this block.

Top module: `dpr_dual_ram`

## Requirements
- R1: The memory holds 2^ADDR_W words of DATA_W bits. A word written by either port, including the highest address 2^ADDR_W-1, can be read back by either port.
- R2: A port is selected only at an edge where its `cs0_n` is 0 and its `cs1` is 1. An edge with `cs0_n`=1 or `cs1`=0 writes nothing, even when `rnw`=0.
- R3: At a selected edge with `rnw`=0, `wdata` is stored at `addr`. That write edge yields no valid read data: in flow-through mode in the cycle after the edge, and in pipelined mode one cycle later.
- R4: With `pipe`=0, a selected edge with `rnw`=1 drives the addressed word on `rdata` with `rvalid`=1 in the cycle after that edge. Any other kind of edge gives `rvalid`=0 in the following cycle.
- R5: With `pipe`=1, the word read at edge k is driven in the cycle after edge k+1. It is valid only if the port was also selected at edge k-1, so two consecutive selected edges are needed after a deselect or a reset.
- R6: `oe_n`=1 forces `rvalid` low at once, without a clock edge, and disturbs no internal state. When `oe_n` returns to 0, the held data appears again.
- R7: Whenever `rvalid` is 0, `rdata` is all zeros.
- R8: If both ports write the same address on the same edge, the word keeps port A's data.
- R9: A read on one port of an address that the other port writes on the same edge returns the previous content. The new content is returned from the next edge on.
- R10: A synchronous active-high reset of a port drives that port's `rvalid` low. The memory contents are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_cs0_n | input | 1 | Port A select, active low |
| a_cs1 | input | 1 | Port A select, active high |
| a_rnw | input | 1 | Port A 1 = read, 0 = write |
| a_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| a_pipe | input | 1 | Port A latency: 0 flow-through, 1 pipelined (static) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when not valid |
| a_rvalid | output | 1 | Port A read data valid |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_cs0_n | input | 1 | Port B select, active low |
| b_cs1 | input | 1 | Port B select, active high |
| b_rnw | input | 1 | Port B 1 = read, 0 = write |
| b_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| b_pipe | input | 1 | Port B latency: 0 flow-through, 1 pipelined (static) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when not valid |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
Two of this block's functions can fall on the same edge and touch the same word: two writes from the two ports, and a write on one port with a read on the other. The bench runs both ports from one clock so that their edges coincide. It then points both ports at one address in the same cycle, both writing, or one writing while the other reads. The result is judged by the word returned in that cycle and by read-backs on later cycles. These must show port A's data surviving the write collision and the pre-write content on the concurrent read. A long random phase over a small address window makes such coincidences frequent in both latency arrangements.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic {
        DPR_FLOW = 1'b0,
        DPR_PIPE = 1'b1
    } dpr_lat_e;

    typedef struct packed {
        logic sel;
        logic rd;
        logic wr;
    } dpr_ctl_t;

    function automatic dpr_ctl_t dpr_decode(input logic cs0_n, input logic cs1, input logic rnw);
        dpr_ctl_t c;
        c.sel = ~cs0_n & cs1;
        c.rd  = c.sel & rnw;
        c.wr  = c.sel & ~rnw;
        return c;
    endfunction

    // Two write banks plus one owner bit per bank: equal bits mean bank A is newer.
    function automatic logic dpr_newer_is_a(input logic own_a, input logic own_b);
        return own_a == own_b;
    endfunction

endpackage

// File: rtl/dpr_bank.sv
module dpr_bank #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter bit FLIP_TAG = 1'b0
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              peer_tag_w,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] q_a,
    output logic [DATA_W-1:0] q_b,
    output logic              tag_a,
    output logic              tag_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_q [DEPTH];
    logic              tag_q  [DEPTH];
    logic              tag_next;

    generate
        if (FLIP_TAG) begin : g_flip
            assign tag_next = ~peer_tag_w;
        end else begin : g_copy
            assign tag_next = peer_tag_w;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (we) begin
            word_q[waddr] <= wdata;
            tag_q[waddr]  <= tag_next;
        end
    end

    assign q_a   = word_q[raddr_a];
    assign q_b   = word_q[raddr_b];
    assign tag_a = tag_q[raddr_a];
    assign tag_b = tag_q[raddr_b];

endmodule

// File: rtl/dpr_port.sv
module dpr_port
    import dpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  dpr_lat_e          lat,
    input  dpr_ctl_t          ctl,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] fresh,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic              rd1, sel1, sel2, pv;
    logic [DATA_W-1:0] flow_q, pipe_q;
    logic              armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd1    <= 1'b0;
            sel1   <= 1'b0;
            sel2   <= 1'b0;
            pv     <= 1'b0;
            flow_q <= '0;
            pipe_q <= '0;
        end else begin
            pv     <= rd1 & sel2;
            sel2   <= sel1;
            sel1   <= ctl.sel;
            rd1    <= ctl.rd;
            pipe_q <= flow_q;
            if (ctl.rd) begin
                flow_q <= fresh;
            end
        end
    end

    always_comb begin
        armed  = (lat == DPR_PIPE) ? pv : rd1;
        rvalid = armed & ~oe_n;
        rdata  = '0;
        if (rvalid) begin
            rdata = (lat == DPR_PIPE) ? pipe_q : flow_q;
        end
    end

endmodule

// File: rtl/dpr_dual_ram.sv
module dpr_dual_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              a_cs0_n,
    input  logic              a_cs1,
    input  logic              a_rnw,
    input  logic              a_oe_n,
    input  logic              a_pipe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              b_cs0_n,
    input  logic              b_cs1,
    input  logic              b_rnw,
    input  logic              b_oe_n,
    input  logic              b_pipe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid
);
    dpr_ctl_t          ctl_a, ctl_b;
    logic              we_b_eff;
    logic [DATA_W-1:0] qa_at_a, qa_at_b, qb_at_a, qb_at_b;
    logic              ta_at_a, ta_at_b, tb_at_a, tb_at_b;
    logic [DATA_W-1:0] fresh_a, fresh_b;

    assign ctl_a = dpr_decode(a_cs0_n, a_cs1, a_rnw);
    assign ctl_b = dpr_decode(b_cs0_n, b_cs1, b_rnw);

    // Same-edge write to one word: port B yields so port A's data stays.
    assign we_b_eff = ctl_b.wr & ~(ctl_a.wr & (a_addr == b_addr));

    dpr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLIP_TAG(1'b0)) u_bank_a (
        .clk        (clk_a),
        .we         (ctl_a.wr),
        .waddr      (a_addr),
        .wdata      (a_wdata),
        .peer_tag_w (tb_at_a),
        .raddr_a    (a_addr),
        .raddr_b    (b_addr),
        .q_a        (qa_at_a),
        .q_b        (qa_at_b),
        .tag_a      (ta_at_a),
        .tag_b      (ta_at_b)
    );

    dpr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLIP_TAG(1'b1)) u_bank_b (
        .clk        (clk_b),
        .we         (we_b_eff),
        .waddr      (b_addr),
        .wdata      (b_wdata),
        .peer_tag_w (ta_at_b),
        .raddr_a    (a_addr),
        .raddr_b    (b_addr),
        .q_a        (qb_at_a),
        .q_b        (qb_at_b),
        .tag_a      (tb_at_a),
        .tag_b      (tb_at_b)
    );

    assign fresh_a = dpr_newer_is_a(ta_at_a, tb_at_a) ? qa_at_a : qb_at_a;
    assign fresh_b = dpr_newer_is_a(ta_at_b, tb_at_b) ? qa_at_b : qb_at_b;

    dpr_port #(.DATA_W(DATA_W)) u_port_a (
        .clk    (clk_a),
        .rst    (rst_a),
        .lat    (dpr_lat_e'(a_pipe)),
        .ctl    (ctl_a),
        .oe_n   (a_oe_n),
        .fresh  (fresh_a),
        .rdata  (a_rdata),
        .rvalid (a_rvalid)
    );

    dpr_port #(.DATA_W(DATA_W)) u_port_b (
        .clk    (clk_b),
        .rst    (rst_b),
        .lat    (dpr_lat_e'(b_pipe)),
        .ctl    (ctl_b),
        .oe_n   (b_oe_n),
        .fresh  (fresh_b),
        .rdata  (b_rdata),
        .rvalid (b_rvalid)
    );

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk_a,
    input logic              rst_a,
    input logic              a_cs0_n,
    input logic              a_cs1,
    input logic              a_rnw,
    input logic              a_oe_n,
    input logic              a_pipe,
    input logic [DATA_W-1:0] a_rdata,
    input logic              a_rvalid,
    input logic              clk_b,
    input logic              rst_b,
    input logic              b_cs0_n,
    input logic              b_cs1,
    input logic              b_rnw,
    input logic              b_oe_n,
    input logic              b_pipe,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_rvalid
);
    logic sel_a, rd_a, wr_a, sel_b, rd_b, wr_b;
    assign sel_a = ~a_cs0_n & a_cs1;
    assign rd_a  = sel_a & a_rnw;
    assign wr_a  = sel_a & ~a_rnw;
    assign sel_b = ~b_cs0_n & b_cs1;
    assign rd_b  = sel_b & b_rnw;
    assign wr_b  = sel_b & ~b_rnw;

    AST_A_IDLE_ZERO:   assert property (@(posedge clk_a) disable iff (rst_a) !a_rvalid |-> a_rdata == '0);                               // R7
    AST_A_OE_BLOCK:    assert property (@(posedge clk_a) disable iff (rst_a) a_oe_n |-> !a_rvalid);                                     // R6
    AST_A_FLOW_QUIET:  assert property (@(posedge clk_a) disable iff (rst_a) (!a_pipe && !$past(rd_a)) |-> !a_rvalid);                  // R4
    AST_A_FLOW_SHOW:   assert property (@(posedge clk_a) disable iff (rst_a) (!a_pipe && $past(rd_a) && !$past(rst_a) && !a_oe_n) |-> a_rvalid); // R4
    AST_A_FLOW_WRITE:  assert property (@(posedge clk_a) disable iff (rst_a) (!a_pipe && $past(wr_a)) |-> !a_rvalid);                   // R3
    AST_A_PIPE_WRITE:  assert property (@(posedge clk_a) disable iff (rst_a) (a_pipe && $past(wr_a, 2)) |-> !a_rvalid);                 // R3
    AST_A_PIPE_DESEL:  assert property (@(posedge clk_a) disable iff (rst_a) (a_pipe && !$past(rd_a, 2)) |-> !a_rvalid);                // R5
    AST_A_PIPE_REARM:  assert property (@(posedge clk_a) disable iff (rst_a) (a_pipe && !$past(sel_a, 3)) |-> !a_rvalid);               // R5

    AST_B_IDLE_ZERO:   assert property (@(posedge clk_b) disable iff (rst_b) !b_rvalid |-> b_rdata == '0);                               // R7
    AST_B_OE_BLOCK:    assert property (@(posedge clk_b) disable iff (rst_b) b_oe_n |-> !b_rvalid);                                     // R6
    AST_B_FLOW_QUIET:  assert property (@(posedge clk_b) disable iff (rst_b) (!b_pipe && !$past(rd_b)) |-> !b_rvalid);                  // R4
    AST_B_FLOW_SHOW:   assert property (@(posedge clk_b) disable iff (rst_b) (!b_pipe && $past(rd_b) && !$past(rst_b) && !b_oe_n) |-> b_rvalid); // R4
    AST_B_FLOW_WRITE:  assert property (@(posedge clk_b) disable iff (rst_b) (!b_pipe && $past(wr_b)) |-> !b_rvalid);                   // R3
    AST_B_PIPE_WRITE:  assert property (@(posedge clk_b) disable iff (rst_b) (b_pipe && $past(wr_b, 2)) |-> !b_rvalid);                 // R3
    AST_B_PIPE_DESEL:  assert property (@(posedge clk_b) disable iff (rst_b) (b_pipe && !$past(rd_b, 2)) |-> !b_rvalid);                // R5
    AST_B_PIPE_REARM:  assert property (@(posedge clk_b) disable iff (rst_b) (b_pipe && !$past(sel_b, 3)) |-> !b_rvalid);               // R5

endmodule

bind dpr_dual_ram dpr_checker #(.DATA_W(DATA_W)) u_dpr_checker (
    .clk_a    (clk_a),
    .rst_a    (rst_a),
    .a_cs0_n  (a_cs0_n),
    .a_cs1    (a_cs1),
    .a_rnw    (a_rnw),
    .a_oe_n   (a_oe_n),
    .a_pipe   (a_pipe),
    .a_rdata  (a_rdata),
    .a_rvalid (a_rvalid),
    .clk_b    (clk_b),
    .rst_b    (rst_b),
    .b_cs0_n  (b_cs0_n),
    .b_cs1    (b_cs1),
    .b_rnw    (b_rnw),
    .b_oe_n   (b_oe_n),
    .b_pipe   (b_pipe),
    .b_rdata  (b_rdata),
    .b_rvalid (b_rvalid)
);

// File: tb/test_dpr_dual_ram.sv
module test_dpr_dual_ram;
    localparam int AW  = 10;
    localparam int DW  = 8;
    localparam int TOP = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    bit d_cs0n [2];
    bit d_cs1  [2];
    bit d_rnw  [2];
    bit d_oen  [2];
    bit d_pipe [2];
    int d_addr [2];
    int d_wd   [2];

    logic [DW-1:0] a_rdata, b_rdata;
    logic          a_rvalid, b_rvalid;

    dpr_dual_ram #(.ADDR_W(AW), .DATA_W(DW)) i_dpr_dual_ram (
        .clk_a    (clk),
        .rst_a    (rst),
        .a_cs0_n  (d_cs0n[0]),
        .a_cs1    (d_cs1[0]),
        .a_rnw    (d_rnw[0]),
        .a_oe_n   (d_oen[0]),
        .a_pipe   (d_pipe[0]),
        .a_addr   (AW'(d_addr[0])),
        .a_wdata  (DW'(d_wd[0])),
        .a_rdata  (a_rdata),
        .a_rvalid (a_rvalid),
        .clk_b    (clk),
        .rst_b    (rst),
        .b_cs0_n  (d_cs0n[1]),
        .b_cs1    (d_cs1[1]),
        .b_rnw    (d_rnw[1]),
        .b_oe_n   (d_oen[1]),
        .b_pipe   (d_pipe[1]),
        .b_addr   (AW'(d_addr[1])),
        .b_wdata  (DW'(d_wd[1])),
        .b_rdata  (b_rdata),
        .b_rvalid (b_rvalid)
    );

    // Behavioural reference: word store plus per-port output history.
    int mem [int];
    bit m_rd1 [2];
    bit m_sel1 [2];
    bit m_sel2 [2];
    bit m_pv  [2];
    int m_flow [2];
    int m_pipe [2];

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R10";

    always @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < 2; p++) begin
                m_rd1[p] = 0; m_sel1[p] = 0; m_sel2[p] = 0; m_pv[p] = 0;
                m_flow[p] = 0; m_pipe[p] = 0;
            end
        end else begin
            bit wr [2];
            for (int p = 0; p < 2; p++) begin
                bit s, r, npv;
                s   = !d_cs0n[p] && d_cs1[p];
                r   = s && d_rnw[p];
                wr[p] = s && !d_rnw[p];
                npv = m_rd1[p] && m_sel2[p];
                m_sel2[p] = m_sel1[p];
                m_sel1[p] = s;
                m_rd1[p]  = r;
                m_pipe[p] = m_flow[p];
                if (r) m_flow[p] = mem.exists(d_addr[p]) ? mem[d_addr[p]] : 0;
                m_pv[p] = npv;
            end
            if (wr[1]) mem[d_addr[1]] = d_wd[1] & 8'hFF;
            if (wr[0]) mem[d_addr[0]] = d_wd[0] & 8'hFF;
        end
    end

    task automatic check_port(input int p);
        bit ev, gv;
        int ed, gd;
        ev = !d_oen[p] && (d_pipe[p] ? m_pv[p] : m_rd1[p]);
        ed = ev ? (d_pipe[p] ? m_pipe[p] : m_flow[p]) : 0;
        gv = (p == 0) ? a_rvalid : b_rvalid;
        gd = (p == 0) ? int'(a_rdata) : int'(b_rdata);
        n_cmp++;
        if (gv !== ev || gd != ed) begin
            n_bad++;
            $display("FAIL %s port %0d: rvalid=%0b rdata=%0h, expected rvalid=%0b rdata=%0h",
                     cur_tag, p, gv, gd, ev, ed);
        end
    endtask

    task automatic compare();
        check_port(0);
        check_port(1);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic drv(input int p, input bit cs0n, input bit cs1, input bit rnw, input int a, input int d);
        d_cs0n[p] = cs0n; d_cs1[p] = cs1; d_rnw[p] = rnw; d_addr[p] = a; d_wd[p] = d;
    endtask

    task automatic rd(input int p, input int a);
        drv(p, 1'b0, 1'b1, 1'b1, a, 0);
    endtask

    task automatic wr(input int p, input int a, input int d);
        drv(p, 1'b0, 1'b1, 1'b0, a, d);
    endtask

    task automatic idle(input int p);
        drv(p, 1'b1, 1'b1, 1'b1, 0, 0);
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            for (int p = 0; p < 2; p++) begin
                drv(p, ($urandom_range(0, 4) == 0), ($urandom_range(0, 4) != 0),
                    $urandom_range(0, 2) != 0, $urandom_range(0, 15), $urandom_range(0, 255));
                d_oen[p] = ($urandom_range(0, 5) == 0);
            end
            cyc();
        end
        for (int p = 0; p < 2; p++) d_oen[p] = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int p = 0; p < 2; p++) begin idle(p); d_oen[p] = 1'b0; end
        d_pipe[0] = 1'b0;
        d_pipe[1] = 1'b1;

        // R10: reset state
        cur_tag = "R10";
        repeat (3) cyc();
        rst = 1'b0;
        repeat (2) cyc();

        // R3: port A fills words 0..15, writes give no valid read output
        cur_tag = "R3";
        for (int i = 0; i < 16; i++) begin wr(0, i, i * 7 + 3); cyc(); end
        idle(0);
        // R1: extremes and cross-port writes
        cur_tag = "R1";
        wr(0, TOP, 8'hA5); wr(1, 16, 8'h5A); cyc();
        rd(0, 16); rd(1, TOP); cyc();
        rd(0, TOP); rd(1, 16); cyc();
        idle(0); idle(1); repeat (3) cyc();

        // R4 / R5: streaming reads, A flow-through, B pipelined
        cur_tag = "R5";
        for (int i = 0; i < 16; i++) begin rd(0, 15 - i); rd(1, i); cyc(); end
        // R5: deselect by cs1 low, then re-arm over two edges
        rd(1, 2); cyc();
        drv(1, 1'b0, 1'b0, 1'b1, 3, 0); cyc();
        rd(1, 4); cyc();
        rd(1, 5); cyc();
        rd(1, 6); cyc();
        idle(1); cyc(); cyc();
        // R4: flow-through single reads separated by deselects
        cur_tag = "R4";
        rd(0, 9); cyc(); idle(0); cyc(); rd(0, 10); cyc(); wr(0, 11, 8'h77); cyc(); rd(0, 11); cyc();
        idle(0); cyc();

        // R2: unselected write attempts with both encodings change nothing
        cur_tag = "R2";
        drv(0, 1'b1, 1'b1, 1'b0, 3, 8'hEE); drv(1, 1'b0, 1'b0, 1'b0, 4, 8'hDD); cyc();
        rd(0, 3); rd(1, 4); cyc();
        rd(0, 4); rd(1, 3); cyc();
        idle(0); idle(1); repeat (2) cyc();

        // R8: same-edge writes to one word
        cur_tag = "R8";
        wr(0, 5, 8'h11); wr(1, 5, 8'h22); cyc();
        rd(0, 5); rd(1, 5); cyc(); cyc(); cyc();
        idle(0); idle(1); cyc();

        // R9: write on one port while the other reads the same word
        cur_tag = "R9";
        wr(0, 6, 8'h33); rd(1, 6); cyc();
        wr(1, 7, 8'h44); rd(0, 7); cyc();
        rd(0, 7); rd(1, 6); cyc(); cyc(); cyc();

        // R6: asynchronous output enable on both ports
        cur_tag = "R6";
        rd(0, 8); rd(1, 8); cyc(); cyc();
        d_oen[0] = 1'b1; d_oen[1] = 1'b1; #2 compare();
        cyc();
        d_oen[0] = 1'b0; d_oen[1] = 1'b0; #2 compare();
        cyc();

        // R7: idle burst, outputs must read zero
        cur_tag = "R7";
        idle(0); drv(1, 1'b0, 1'b0, 1'b1, 0, 0); repeat (4) cyc();

        // R1: random mix over the initialised window
        cur_tag = "R1";
        random_run(400);

        // R10: reset keeps memory; swap latency modes while in reset
        cur_tag = "R10";
        idle(0); idle(1);
        rst = 1'b1;
        d_pipe[0] = 1'b1; d_pipe[1] = 1'b0;
        repeat (2) cyc();
        rst = 1'b0;
        rd(0, TOP); rd(1, 16); cyc(); cyc(); cyc();
        idle(0); idle(1); cyc(); cyc();

        cur_tag = "R8";
        wr(0, 12, 8'h9C); wr(1, 12, 8'h3E); cyc();
        rd(0, 12); rd(1, 12); cyc(); cyc(); cyc();

        cur_tag = "R5";
        random_run(400);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule